// File: doc/BRIEF.md
# TFT Column Driver Input Front-End

This block is the digital input stage of a color TFT column driver with 120 column positions. Each position holds one red, one green and one blue 6-bit sample. A single start token runs through a bidirectional shift register that advances on the rising edge of the shift clock. At each edge, the position the token occupies captures the three color buses.

A load strobe, sampled on the same clock, copies the whole captured line into an output holding register. The copy is shaped on the way in: binary or grayscale format, bitwise polarity inversion, and an optional disabled middle band. The held codes drive the digital-to-analog stage that sits outside this block. A registered power-save input marks every output channel as high-impedance, and a DAC-enable flag reports the active format.

A combinational readback port, indexed by position, returns the held codes and the high-impedance flag of any channel. Index k (0-based) addresses position k+1.

Top module: `lcd_col_front`

## Requirements
- R1: A position captures red_i, grn_i and blu_i (bit 5 is the MSB) at the rising edge where the token occupies it. Exactly one position or none holds the token.
- R2: With dir_i high, a pulse on stp_r_i at an edge places the token at position 1, and each later edge moves it one position up to position 120. carry_l_o is high for the one cycle after position 120 captures, and carry_r_o stays low.
- R3: With dir_i low, the roles are mirrored. stp_l_i starts the token at position 120, positions fill downward to 1, and carry_r_o pulses for one cycle after position 1 captures.
- R4: When load_i is high at an edge, every position's captured codes are transferred to the holding register. Readback at index k then shows position k+1, and an index of 120 or more reads zero.
- R5: With inv_i low at the load edge, held codes equal the shaped captured codes. With inv_i high, every held code is their bitwise inverse.
- R6: With full_i low, positions 55 to 66 are disabled. The token jumps between positions 54 and 67 without spending a clock in the band. At load, disabled positions hold code 0 and have their high-impedance flag set.
- R7: With bin_i high at load, each held code becomes 63 if bit 5 was set and 0 otherwise, before inversion, and dac_en_o goes low. With bin_i low, codes pass through and dac_en_o goes high.
- R8: When psave_i is high at an edge, rd_hiz_o is high for every index in the following cycle. When psave_i is low, the flag reflects only the disabled band.
- R9: Reset clears the token, both carries, all captured and held codes, all flags and dac_en_o.
- R10: A start pulse while a token is already running restarts it at the first position, and the old token is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Shift direction: 1 fills 1..120, 0 fills 120..1 |
| stp_r_i | input | 1 | Right-end start pulse (used when dir_i=1) |
| stp_l_i | input | 1 | Left-end start pulse (used when dir_i=0) |
| carry_r_o | output | 1 | Right-end carry (driven when dir_i=0) |
| carry_l_o | output | 1 | Left-end carry (driven when dir_i=1) |
| red_i | input | 6 | Red sample |
| grn_i | input | 6 | Green sample |
| blu_i | input | 6 | Blue sample |
| load_i | input | 1 | Line transfer strobe |
| inv_i | input | 1 | Polarity inversion at load |
| full_i | input | 1 | 1: all 120 positions, 0: band 55..66 disabled |
| bin_i | input | 1 | 1: binary format, 0: 6-bit grayscale |
| psave_i | input | 1 | Power save, sampled each edge |
| rd_idx_i | input | 7 | Readback position index (0-based) |
| rd_red_o | output | 6 | Held red code at rd_idx_i |
| rd_grn_o | output | 6 | Held green code at rd_idx_i |
| rd_blu_o | output | 6 | Held blue code at rd_idx_i |
| rd_hiz_o | output | 1 | High-impedance flag at rd_idx_i |
| dac_en_o | output | 1 | DAC enable from the last load |

## Verification
A token that is lost, duplicated or steered the wrong way cannot be seen until the end of a line. It shows up as a carry pulse on the wrong pin, or a pulse one or more cycles off from the expected edge, about 120 clocks after the start. A misplaced capture stays hidden until the next load. After that, the readback of the affected position differs from the model in the very next cycle. Comparing every cycle, while sweeping the readback index across all positions, places such a fault within one line time.

// File: rtl/lcd_fe_pkg.sv
package lcd_fe_pkg;
  localparam int CW = 6;

  typedef struct packed {
    logic [CW-1:0] r;
    logic [CW-1:0] g;
    logic [CW-1:0] b;
  } rgb_t;

  function automatic logic [CW-1:0] shape_ch(logic [CW-1:0] v, logic bin, logic inv);
    logic [CW-1:0] c;
    c = bin ? {CW{v[CW-1]}} : v;
    return c ^ {CW{inv}};
  endfunction

  function automatic rgb_t shape_px(rgb_t v, logic bin, logic inv);
    rgb_t o;
    o.r = shape_ch(v.r, bin, inv);
    o.g = shape_ch(v.g, bin, inv);
    o.b = shape_ch(v.b, bin, inv);
    return o;
  endfunction
endpackage

// File: rtl/lcd_tok_shift.sv
module lcd_tok_shift #(
  parameter int N_POS = 120,
  parameter int B_LO  = 54,   // 0-based first disabled position
  parameter int B_HI  = 65    // 0-based last disabled position
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  input  logic             full_i,
  input  logic             start_i,
  output logic [N_POS-1:0] tok_o,
  output logic             carry_l_o,
  output logic             carry_r_o
);
  logic [N_POS-1:0] tok_q, tok_nxt;
  logic             carry_l_q, carry_r_q;

  for (genvar gp = 0; gp < N_POS; gp++) begin : g_pos
    localparam bit IN_BAND = (gp >= B_LO) && (gp <= B_HI);
    logic from_lo, from_hi, act;

    if (gp == 0) begin : g_lo0
      assign from_lo = 1'b0;
    end else if (gp == B_HI + 1) begin : g_lojmp
      assign from_lo = full_i ? tok_q[gp-1] : tok_q[B_LO-1];
    end else begin : g_lon
      assign from_lo = tok_q[gp-1];
    end

    if (gp == N_POS - 1) begin : g_hi0
      assign from_hi = 1'b0;
    end else if (gp == B_LO - 1) begin : g_hijmp
      assign from_hi = full_i ? tok_q[gp+1] : tok_q[B_HI+1];
    end else begin : g_hin
      assign from_hi = tok_q[gp+1];
    end

    assign act = full_i | ~IN_BAND;
    assign tok_nxt[gp] = start_i ? (dir_i ? (gp == 0) : (gp == N_POS - 1))
                                 : act & (dir_i ? from_lo : from_hi);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q     <= '0;
      carry_l_q <= 1'b0;
      carry_r_q <= 1'b0;
    end else begin
      tok_q     <= tok_nxt;
      carry_l_q <= dir_i & tok_q[N_POS-1];
      carry_r_q <= ~dir_i & tok_q[0];
    end
  end

  assign tok_o     = tok_q;
  assign carry_l_o = carry_l_q;
  assign carry_r_o = carry_r_q;

  assert_tok_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tok_q));

  assert_band_skip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_i |=> (tok_q[B_HI:B_LO] == '0));

  assert_carry_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_l_q |=> !carry_l_q);

  assert_carry_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_r_q |=> !carry_r_q);
endmodule

// File: rtl/lcd_line_store.sv
module lcd_line_store
  import lcd_fe_pkg::*;
#(
  parameter int N_POS = 120,
  parameter int B_LO  = 54,
  parameter int B_HI  = 65,
  localparam int IW   = $clog2(N_POS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_POS-1:0] tok_i,
  input  rgb_t             pix_i,
  input  logic             load_i,
  input  logic             inv_i,
  input  logic             bin_i,
  input  logic             full_i,
  input  logic [IW-1:0]    rd_idx_i,
  output rgb_t             rd_pix_o,
  output logic             rd_dis_o
);
  rgb_t             lat_q  [N_POS];
  rgb_t             hold_q [N_POS];
  logic [N_POS-1:0] dis_q;

  for (genvar gp = 0; gp < N_POS; gp++) begin : g_cell
    localparam bit IN_BAND = (gp >= B_LO) && (gp <= B_HI);
    logic dis_n;
    assign dis_n = ~full_i & IN_BAND;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lat_q[gp]  <= '0;
        hold_q[gp] <= '0;
        dis_q[gp]  <= 1'b0;
      end else begin
        if (tok_i[gp]) lat_q[gp] <= pix_i;
        if (load_i) begin
          hold_q[gp] <= dis_n ? '0 : shape_px(lat_q[gp], bin_i, inv_i);
          dis_q[gp]  <= dis_n;
        end
      end
    end
  end

  always_comb begin
    rd_pix_o = '0;
    rd_dis_o = 1'b0;
    if (int'(rd_idx_i) < N_POS) begin
      rd_pix_o = hold_q[rd_idx_i];
      rd_dis_o = dis_q[rd_idx_i];
    end
  end
endmodule

// File: rtl/lcd_col_front.sv
module lcd_col_front
  import lcd_fe_pkg::*;
#(
  parameter int N_POS = 120,
  parameter int B_LO  = 54,
  parameter int B_HI  = 65,
  localparam int IW   = $clog2(N_POS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_i,
  input  logic          stp_r_i,
  input  logic          stp_l_i,
  output logic          carry_r_o,
  output logic          carry_l_o,
  input  logic [CW-1:0] red_i,
  input  logic [CW-1:0] grn_i,
  input  logic [CW-1:0] blu_i,
  input  logic          load_i,
  input  logic          inv_i,
  input  logic          full_i,
  input  logic          bin_i,
  input  logic          psave_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [CW-1:0] rd_red_o,
  output logic [CW-1:0] rd_grn_o,
  output logic [CW-1:0] rd_blu_o,
  output logic          rd_hiz_o,
  output logic          dac_en_o
);
  logic [N_POS-1:0] tok;
  logic             start;
  rgb_t             pix, rd_pix;
  logic             rd_dis;
  logic             ps_q, dac_q;

  assign start = dir_i ? stp_r_i : stp_l_i;
  assign pix   = '{r: red_i, g: grn_i, b: blu_i};

  lcd_tok_shift #(.N_POS(N_POS), .B_LO(B_LO), .B_HI(B_HI)) u_shift (
    .clk_i, .rst_ni, .dir_i, .full_i,
    .start_i   (start),
    .tok_o     (tok),
    .carry_l_o (carry_l_o),
    .carry_r_o (carry_r_o)
  );

  lcd_line_store #(.N_POS(N_POS), .B_LO(B_LO), .B_HI(B_HI)) u_store (
    .clk_i, .rst_ni,
    .tok_i    (tok),
    .pix_i    (pix),
    .load_i, .inv_i, .bin_i, .full_i, .rd_idx_i,
    .rd_pix_o (rd_pix),
    .rd_dis_o (rd_dis)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q  <= 1'b0;
      dac_q <= 1'b0;
    end else begin
      ps_q <= psave_i;
      if (load_i) dac_q <= ~bin_i;
    end
  end

  assign rd_red_o = rd_pix.r;
  assign rd_grn_o = rd_pix.g;
  assign rd_blu_o = rd_pix.b;
  assign rd_hiz_o = ps_q | rd_dis;
  assign dac_en_o = dac_q;

  assert_dac_fmt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (dac_en_o == !$past(bin_i)));

  assert_psave_hiz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psave_i |=> rd_hiz_o);
endmodule

// File: tb/lcd_col_front_tb.sv
module lcd_col_front_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       dir = 1'b1, stp_r = 1'b0, stp_l = 1'b0;
  logic       carry_r, carry_l;
  logic [5:0] red = '0, grn = '0, blu = '0;
  logic       load = 1'b0, inv = 1'b0, full = 1'b1, bin = 1'b0, psave = 1'b0;
  logic [6:0] rd_idx = '0;
  logic [5:0] rd_red, rd_grn, rd_blu;
  logic       rd_hiz, dac_en;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcd_col_front u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .stp_r_i(stp_r), .stp_l_i(stp_l),
    .carry_r_o(carry_r), .carry_l_o(carry_l), .red_i(red), .grn_i(grn), .blu_i(blu),
    .load_i(load), .inv_i(inv), .full_i(full), .bin_i(bin), .psave_i(psave),
    .rd_idx_i(rd_idx), .rd_red_o(rd_red), .rd_grn_o(rd_grn), .rd_blu_o(rd_blu),
    .rd_hiz_o(rd_hiz), .dac_en_o(dac_en)
  );

  // behavioural reference
  int lr[120], lg[120], lb[120], hr[120], hg[120], hb[120];
  bit hd[120];
  int mpos = -1;
  bit mcl, mcr, mps, mdac;

  function automatic int shp(int v, bit b, bit iv);
    int c;
    c = b ? (((v & 32) != 0) ? 63 : 0) : v;
    return iv ? (c ^ 63) : c;
  endfunction

  function automatic bit in_band(int p);
    return p >= 54 && p <= 65;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 120; p++) begin
        lr[p] = 0; lg[p] = 0; lb[p] = 0; hr[p] = 0; hg[p] = 0; hb[p] = 0; hd[p] = 0;
      end
      mpos = -1; mcl = 0; mcr = 0; mps = 0; mdac = 0;
    end else begin
      int np;
      if (load) begin
        for (int p = 0; p < 120; p++) begin
          if (!full && in_band(p)) begin
            hr[p] = 0; hg[p] = 0; hb[p] = 0; hd[p] = 1;
          end else begin
            hr[p] = shp(lr[p], bin, inv); hg[p] = shp(lg[p], bin, inv);
            hb[p] = shp(lb[p], bin, inv); hd[p] = 0;
          end
        end
        mdac = !bin;
      end
      mps = psave;
      mcl = dir && mpos == 119;
      mcr = !dir && mpos == 0;
      if (mpos >= 0) begin
        lr[mpos] = red; lg[mpos] = grn; lb[mpos] = blu;
      end
      if (dir ? stp_r : stp_l) np = dir ? 0 : 119;
      else if (mpos < 0) np = -1;
      else begin
        if (!full && dir && mpos == 53) np = 66;
        else if (!full && !dir && mpos == 66) np = 53;
        else np = dir ? mpos + 1 : mpos - 1;
        if (np < 0 || np > 119) np = -1;
        if (np >= 0 && !full && in_band(np)) np = -1;
      end
      mpos = np;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    if (rst_n && !done) begin
      int i;
      #5;
      i = rd_idx;
      chk(dir ? "R2 carry_l" : "R3 carry_l", carry_l, mcl);
      chk(dir ? "R2 carry_r" : "R3 carry_r", carry_r, mcr);
      chk("R7 dac_en", dac_en, mdac);
      chk("R4 red", rd_red, i < 120 ? hr[i] : 0);
      chk("R4 grn", rd_grn, i < 120 ? hg[i] : 0);
      chk("R4 blu", rd_blu, i < 120 ? hb[i] : 0);
      chk("R8 hiz", rd_hiz, mps || (i < 120 && hd[i]));
    end
  end

  int cyc = 0;

  task automatic step();
    @(negedge clk);
    cyc++;
    red = 6'((cyc * 7 + 3) & 63);
    grn = 6'((cyc * 13 + 40) & 63);
    blu = 6'((cyc * 29 + 17) & 63);
    rd_idx = 7'((cyc * 37) % 128);
    stp_r = 0; stp_l = 0; load = 0;
  endtask

  task automatic run_line(bit d, bit f);
    step();
    dir = d; full = f;
    if (d) stp_r = 1; else stp_l = 1;
    for (int k = 0; k < 124; k++) step();
  endtask

  task automatic do_load(bit iv, bit b);
    step();
    load = 1; inv = iv; bin = b;
    step();
  endtask

  task automatic rd(string tag, int idx, int er, int eh);
    @(negedge clk);
    rd_idx = 7'(idx);
    #2;
    chk(tag, rd_red, er);
    chk(tag, rd_hiz, eh);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #35;
    // R9 reset state
    chk("R9 carry_l", carry_l, 0);
    chk("R9 carry_r", carry_r, 0);
    chk("R9 dac_en", dac_en, 0);
    chk("R9 red", rd_red, 0);
    chk("R9 hiz", rd_hiz, 0);
    @(negedge clk); rst_n = 1;

    run_line(1, 1);
    do_load(0, 0);
    rd("R1 pos1", 0, hr[0], 0);
    rd("R4 pos120", 119, hr[119], 0);
    rd("R4 idx out of range", 125, 0, 0);
    chk("R7 dac high in grayscale", dac_en, 1);

    run_line(0, 1);
    do_load(1, 0);
    rd("R5 inverted pos30", 29, hr[29], 0);
    chk("R5 inverse of raw", rd_red, lr[29] ^ 63);

    run_line(1, 0);
    do_load(0, 0);
    rd("R6 band pos60", 59, 0, 1);
    rd("R6 band pos55", 54, 0, 1);
    rd("R6 after band pos67", 66, hr[66], 0);

    run_line(0, 0);
    do_load(0, 1);
    rd("R7 binary pos10", 9, hr[9], 0);
    chk("R7 binary code is 0 or 63", (rd_red == 0 || rd_red == 63), 1);
    chk("R7 dac low in binary", dac_en, 0);

    // R10 restart mid-line
    step(); dir = 1; full = 1; stp_r = 1;
    for (int k = 0; k < 30; k++) step();
    run_line(1, 1);
    do_load(0, 0);
    rd("R10 restart pos1", 0, hr[0], 0);

    // R8 power save
    step(); psave = 1;
    step();
    rd("R8 hiz pos5", 4, hr[4], 1);
    rd("R8 hiz pos100", 99, hr[99], 1);
    psave = 0;
    step(); step();
    rd("R8 normal pos5", 4, hr[4], 0);

    step(); step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule